// File: doc/BRIEF.md
# Atomic Exchange-Add and Compare-Exchange Engine

This block performs one locked read-modify-write on a memory operand per command. A one-cycle start pulse hands it an opcode, an operand size, an address, a source value and an accumulator value. The engine reads the operand, computes a result, writes memory back only when the operation calls for it, and then returns an updated source value, an updated accumulator value and four arithmetic flags on a one-cycle done pulse. A lock output stays high from the read request until the write is issued or skipped, so a surrounding fabric can keep other masters off the location.

There are two operations. Exchange-add stores the sum of the memory value and the source in memory and returns the old memory value in place of the source. Compare-exchange tests the accumulator against the memory value. On a match it stores the source in memory. On a mismatch it leaves memory alone and returns the memory value as the new accumulator. The widest size is 64 bits, which gives a double-width compare-exchange of a full accumulator pair against a full memory word. Memory is reached through a simple request port. Read data comes back on a valid strobe after any latency, and a write is taken in the cycle it is requested.

Top module: `atomic_rmw_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `lock_o`, `mem_req_o`, `mem_we_o` and `done_o` are low.
- R2: With `op_i`=0 (exchange-add), memory receives (memory + source) truncated to the operand size, and `src_o` returns the old memory value. A memory value of 0x12 with a source of 0x02 at 8 bits writes 0x14 and returns 0x12. `acc_o` returns the accumulator unchanged.
- R3: Exchange-add sets its flags as an add at the operand size: `cf_o` is the carry out of the top bit, `zf_o` is set when the truncated sum is zero, `sf_o` is the top bit of the sum, and `of_o` is set when both addends share a sign that differs from the sign of the sum.
- R4: With `op_i`=1 (compare-exchange), when the accumulator equals the memory value, the source is written to memory, `zf_o`=1, `acc_o` returns the accumulator and `src_o` returns the source.
- R5: When compare-exchange finds the accumulator and the memory value unequal, no write request is issued, `zf_o`=0 and `acc_o` returns the memory value.
- R6: `size_i` encodes 0=8, 1=16, 2=32 and 3=64 bits. At size 3, compare-exchange compares and replaces all 64 bits, and exchange-add adds all 64 bits.
- R7: Below 64 bits only the low bits of the source, the accumulator and the memory value take part. Bits above the operand size are zero in `src_o`, `acc_o` and `mem_wdata_o`, and `mem_size_o` carries the size code for a partial write.
- R8: `mem_req_o` (read, `mem_we_o`=0) rises one cycle after the start is taken. The engine waits any number of cycles for `mem_rvalid_i`. After data arrives there is one compute cycle, then a one-cycle write request if one is needed, then `done_o`.
- R9: `lock_o` rises together with the read request, stays high through the wait, the compute and the write, and is low in the done cycle.
- R10: `done_o` is high for exactly one cycle. The results are valid in that cycle and hold their values until the next command finishes.
- R11: A start pulse that arrives while a command is in progress is ignored and leaves no command pending.
- R12: Compare-exchange sets the remaining flags as a compare of the accumulator minus the memory value: `cf_o` is the borrow, `sf_o` is the top bit of the difference, and `of_o` is the signed overflow of that subtraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command pulse, taken only when idle |
| op_i | input | 1 | 0 = exchange-add, 1 = compare-exchange |
| size_i | input | 2 | Operand size code (0=8, 1=16, 2=32, 3=64 bits) |
| addr_i | input | ADDR_W | Operand address |
| src_i | input | 64 | Source value (replacement value for compare-exchange) |
| acc_i | input | 64 | Accumulator value (compare value) |
| mem_req_o | output | 1 | Memory request, one cycle per access |
| mem_we_o | output | 1 | Write qualifier for the request |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_size_o | output | 2 | Access size code |
| mem_wdata_o | output | 64 | Write data, zero above the operand size |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| lock_o | output | 1 | Held across the locked sequence |
| done_o | output | 1 | One-cycle completion pulse |
| src_o | output | 64 | Returned source value |
| acc_o | output | 64 | Returned accumulator value |
| cf_o | output | 1 | Carry or borrow flag |
| zf_o | output | 1 | Zero or equal flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Signed overflow flag |

## Verification
The hardest case to reach from the ports is a second start that arrives while the engine waits on slow read data. If it were taken, it would change the latched address or operands, or it would queue a second locked sequence. The stimulus raises a start with different operands in the first wait cycle of a long-latency compare-exchange. It then checks that the results match the first command, and that in the cycle after done the lock and request stay low. Narrow operands are given garbage in their upper bits to show that those bits are zero in every returned value and in the write data.

// File: rtl/armw_pkg.sv
package armw_pkg;

  typedef enum logic {
    OP_XADD    = 1'b0,
    OP_CMPXCHG = 1'b1
  } armw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_CALC,
    ST_WRITE,
    ST_DONE
  } armw_state_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
  } armw_flags_t;

endpackage

// File: rtl/armw_alu.sv
module armw_alu
  import armw_pkg::*;
#(
  parameter int BASE_W    = 8,
  parameter int NUM_SIZES = 4,
  localparam int DATA_W   = BASE_W << (NUM_SIZES - 1),
  localparam int SZ_W     = $clog2(NUM_SIZES)
) (
  input  logic              op_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [DATA_W-1:0] dest_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] dest_m_o,
  output logic [DATA_W-1:0] src_m_o,
  output logic [DATA_W-1:0] acc_m_o,
  output logic              eq_o,
  output armw_flags_t       flags_o
);

  logic [DATA_W-1:0]    mask_tab [NUM_SIZES];
  logic [DATA_W-1:0]    mask;
  logic [DATA_W:0]      add_full;
  logic [DATA_W:0]      sub_full;
  logic [NUM_SIZES-1:0] add_c, add_s, sub_b, sub_s, d_msb, s_msb, a_msb;
  logic                 c_add, s_add, b_sub, s_sub, dm, sm, am;

  // one slice per supported operand width
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int W = BASE_W << g;
    assign mask_tab[g] = {DATA_W{1'b1}} >> (DATA_W - W);
    assign add_c[g]    = add_full[W];
    assign add_s[g]    = add_full[W-1];
    assign sub_b[g]    = sub_full[W];
    assign sub_s[g]    = sub_full[W-1];
    assign d_msb[g]    = dest_m_o[W-1];
    assign s_msb[g]    = src_m_o[W-1];
    assign a_msb[g]    = acc_m_o[W-1];
  end

  assign mask     = mask_tab[size_i];
  assign dest_m_o = dest_i & mask;
  assign src_m_o  = src_i & mask;
  assign acc_m_o  = acc_i & mask;

  assign add_full = {1'b0, dest_m_o} + {1'b0, src_m_o};
  assign sub_full = {1'b0, acc_m_o} - {1'b0, dest_m_o};

  assign sum_o = add_full[DATA_W-1:0] & mask;
  assign eq_o  = ~|(sub_full[DATA_W-1:0] & mask);

  assign c_add = add_c[size_i];
  assign s_add = add_s[size_i];
  assign b_sub = sub_b[size_i];
  assign s_sub = sub_s[size_i];
  assign dm    = d_msb[size_i];
  assign sm    = s_msb[size_i];
  assign am    = a_msb[size_i];

  always_comb begin
    if (op_i == OP_XADD) begin
      flags_o.cf = c_add;
      flags_o.zf = ~|sum_o;
      flags_o.sf = s_add;
      flags_o.of = (dm == sm) && (s_add != dm);
    end else begin
      flags_o.cf = b_sub;
      flags_o.zf = eq_o;
      flags_o.sf = s_sub;
      flags_o.of = (am != dm) && (s_sub != am);
    end
  end

endmodule

// File: rtl/armw_ctrl.sv
module armw_ctrl
  import armw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic rvalid_i,
  input  logic need_write_i,
  output logic accept_o,
  output logic capture_o,
  output logic calc_o,
  output logic req_o,
  output logic we_o,
  output logic lock_o,
  output logic done_o
);

  armw_state_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start_i) nxt = ST_READ;
      ST_READ:  nxt = ST_WAIT;
      ST_WAIT:  if (rvalid_i) nxt = ST_CALC;
      ST_CALC:  nxt = need_write_i ? ST_WRITE : ST_DONE;
      ST_WRITE: nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign accept_o  = (state == ST_IDLE) && start_i;
  assign capture_o = (state == ST_WAIT) && rvalid_i;
  assign calc_o    = (state == ST_CALC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      req_o  <= 1'b0;
      we_o   <= 1'b0;
      lock_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      state  <= nxt;
      req_o  <= (nxt == ST_READ) || (nxt == ST_WRITE);
      we_o   <= (nxt == ST_WRITE);
      lock_o <= (nxt == ST_READ) || (nxt == ST_WAIT) ||
                (nxt == ST_CALC) || (nxt == ST_WRITE);
      done_o <= (nxt == ST_DONE);
    end
  end

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import armw_pkg::*;
#(
  parameter int BASE_W    = 8,
  parameter int NUM_SIZES = 4,
  parameter int ADDR_W    = 16,
  localparam int DATA_W   = BASE_W << (NUM_SIZES - 1),
  localparam int SZ_W     = $clog2(NUM_SIZES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [SZ_W-1:0]   mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              lock_o,
  output logic              done_o,
  output logic [DATA_W-1:0] src_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              cf_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              of_o
);

  logic              op_q;
  logic [SZ_W-1:0]   size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] src_q, acc_q, dest_q;
  logic              accept, capture, calc, need_write;
  logic [DATA_W-1:0] sum, dest_m, src_m, acc_m;
  logic              eq;
  armw_flags_t       flags;

  armw_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .rvalid_i    (mem_rvalid_i),
    .need_write_i(need_write),
    .accept_o    (accept),
    .capture_o   (capture),
    .calc_o      (calc),
    .req_o       (mem_req_o),
    .we_o        (mem_we_o),
    .lock_o      (lock_o),
    .done_o      (done_o)
  );

  armw_alu #(
    .BASE_W   (BASE_W),
    .NUM_SIZES(NUM_SIZES)
  ) u_alu (
    .op_i    (op_q),
    .size_i  (size_q),
    .dest_i  (dest_q),
    .src_i   (src_q),
    .acc_i   (acc_q),
    .sum_o   (sum),
    .dest_m_o(dest_m),
    .src_m_o (src_m),
    .acc_m_o (acc_m),
    .eq_o    (eq),
    .flags_o (flags)
  );

  assign need_write = (op_q == OP_XADD) || eq;
  assign mem_addr_o = addr_q;
  assign mem_size_o = size_q;

  // command capture
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= 1'b0;
      size_q <= '0;
      addr_q <= '0;
      src_q  <= '0;
      acc_q  <= '0;
    end else if (accept) begin
      op_q   <= op_i;
      size_q <= size_i;
      addr_q <= addr_i;
      src_q  <= src_i;
      acc_q  <= acc_i;
    end
  end

  // operand read
  always_ff @(posedge clk) begin
    if (rst)          dest_q <= '0;
    else if (capture) dest_q <= mem_rdata_i;
  end

  // result registers
  always_ff @(posedge clk) begin
    if (rst) begin
      src_o       <= '0;
      acc_o       <= '0;
      mem_wdata_o <= '0;
      cf_o        <= 1'b0;
      zf_o        <= 1'b0;
      sf_o        <= 1'b0;
      of_o        <= 1'b0;
    end else if (calc) begin
      cf_o <= flags.cf;
      zf_o <= flags.zf;
      sf_o <= flags.sf;
      of_o <= flags.of;
      if (op_q == OP_XADD) begin
        src_o       <= dest_m;
        acc_o       <= acc_m;
        mem_wdata_o <= sum;
      end else begin
        src_o       <= src_m;
        acc_o       <= eq ? acc_m : dest_m;
        mem_wdata_o <= src_m;
      end
    end
  end

endmodule

// File: rtl/armw_checker.sv
module armw_checker (
  input logic clk,
  input logic rst,
  input logic mem_req_o,
  input logic mem_we_o,
  input logic lock_o,
  input logic done_o
);

  // R9
  req_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> lock_o);

  // R8
  write_is_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> mem_req_o);

  // R8
  single_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |=> !mem_req_o);

  // R9
  lock_opens_with_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> (mem_req_o && !mem_we_o));

  // R9
  unlock_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_o) |-> done_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9
  done_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !lock_o);

endmodule

bind atomic_rmw_unit armw_checker u_armw_checker (
  .clk      (clk),
  .rst      (rst),
  .mem_req_o(mem_req_o),
  .mem_we_o (mem_we_o),
  .lock_o   (lock_o),
  .done_o   (done_o)
);

// File: tb/tb_atomic_rmw_unit.sv
module tb_atomic_rmw_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        op_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [15:0] addr_i = '0;
  logic [63:0] src_i = '0, acc_i = '0;
  logic        mem_req_o, mem_we_o, mem_rvalid_i = 1'b0;
  logic [15:0] mem_addr_o;
  logic [1:0]  mem_size_o;
  logic [63:0] mem_wdata_o, mem_rdata_i = '0;
  logic        lock_o, done_o, cf_o, zf_o, sf_o, of_o;
  logic [63:0] src_o, acc_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] mem [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_rmw_unit dut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .size_i(size_i),
    .addr_i(addr_i), .src_i(src_i), .acc_i(acc_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_size_o(mem_size_o), .mem_wdata_o(mem_wdata_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .lock_o(lock_o), .done_o(done_o), .src_o(src_o), .acc_o(acc_o),
    .cf_o(cf_o), .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic chk_ctl(input string req, input logic e_req, input logic e_we,
                         input logic e_lock, input logic e_done);
    chk(req, "mem_req", 64'(mem_req_o), 64'(e_req));
    chk(req, "mem_we",  64'(mem_we_o),  64'(e_we));
    chk(req, "lock",    64'(lock_o),    64'(e_lock));
    chk(req, "done",    64'(done_o),    64'(e_done));
  endtask

  // behavioural reference: one command, compared on every clock
  task automatic run_op(input string req, input logic op, input logic [1:0] sz,
                        input logic [3:0] a, input logic [63:0] s,
                        input logic [63:0] acc, input int lat, input bit poke);
    int w;
    logic [63:0] m, d, sm, am, r, diff, e_src, e_acc, wval;
    logic [64:0] big;
    logic e_cf, e_zf, e_sf, e_of, wr;
    w  = 8 << sz;
    m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    d  = mem[a] & m;
    sm = s & m;
    am = acc & m;
    if (op == 1'b0) begin
      big  = {1'b0, d} + {1'b0, sm};
      r    = big[63:0] & m;
      e_cf = (big > {1'b0, m});
      e_zf = (r == 0);
      e_sf = r[w-1];
      e_of = (d[w-1] == sm[w-1]) && (r[w-1] != d[w-1]);
      e_src = d; e_acc = am; wr = 1'b1; wval = r;
    end else begin
      diff = (am - d) & m;
      e_cf = (am < d);
      e_zf = (am == d);
      e_sf = diff[w-1];
      e_of = (am[w-1] != d[w-1]) && (diff[w-1] != am[w-1]);
      e_src = sm; e_acc = (am == d) ? am : d; wr = (am == d); wval = sm;
    end

    @(negedge clk);
    start_i = 1'b1; op_i = op; size_i = sz; addr_i = {12'd0, a};
    src_i = s; acc_i = acc;
    @(negedge clk);
    start_i = 1'b0;
    chk_ctl({req, " R8 read issue"}, 1'b1, 1'b0, 1'b1, 1'b0);
    chk({req, " R8"}, "mem_addr", 64'(mem_addr_o), 64'(a));
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk_ctl({req, " R9 wait"}, 1'b0, 1'b0, 1'b1, 1'b0);
      if (poke && i == 0) begin
        start_i = 1'b1; op_i = ~op; size_i = 2'd3; addr_i = 16'd15;
        src_i = '1; acc_i = '1;
      end else begin
        start_i = 1'b0;
      end
      if (i == lat - 1) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = mem[a];
      end
    end
    @(negedge clk);
    start_i = 1'b0; mem_rvalid_i = 1'b0; mem_rdata_i = '0;
    chk_ctl({req, " R9 compute"}, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    if (wr) begin
      chk_ctl({req, " R8 write"}, 1'b1, 1'b1, 1'b1, 1'b0);
      chk({req, " R7"}, "wdata", mem_wdata_o, wval);
      chk({req, " R7"}, "mem_size", 64'(mem_size_o), 64'(sz));
      mem[a] = (mem[a] & ~m) | (mem_wdata_o & m);
      @(negedge clk);
    end
    chk_ctl({req, " R10 done"}, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(req, "src_o", src_o, e_src);
    chk(req, "acc_o", acc_o, e_acc);
    chk(req, "cf", 64'(cf_o), 64'(e_cf));
    chk(req, "zf", 64'(zf_o), 64'(e_zf));
    chk(req, "sf", 64'(sf_o), 64'(e_sf));
    chk(req, "of", 64'(of_o), 64'(e_of));
    @(negedge clk);
    chk_ctl({req, " R11 R10 after done"}, 1'b0, 1'b0, 1'b0, 1'b0);
    chk({req, " R10 hold"}, "src_o", src_o, e_src);
    chk({req, " R10 hold"}, "acc_o", acc_o, e_acc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 64'hA5A5_0000_0000_0000 + 64'(i);
    repeat (3) @(negedge clk);
    chk_ctl("R1 in reset", 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk_ctl("R1 after reset", 1'b0, 1'b0, 1'b0, 1'b0);

    // R2 byte example 12h + 02h
    mem[1] = 64'h0000_0000_0000_0012;
    run_op("R2 xadd8", 1'b0, 2'd0, 4'd1, 64'h02, 64'h55, 1, 1'b0);
    chk("R2", "mem after", mem[1], 64'h14);
    // R7 upper garbage ignored at 8 bits
    mem[2] = 64'hFFEE_DDCC_BBAA_99F0;
    run_op("R7 xadd8 garbage", 1'b0, 2'd0, 4'd2, 64'hDEAD_BEEF_0000_1120,
           64'hFFFF_FFFF_FFFF_FF77, 2, 1'b0);
    chk("R7", "mem upper kept", mem[2], 64'hFFEE_DDCC_BBAA_9910);
    // R3 carry to zero at 16 bits
    mem[3] = 64'h1234_0000_0000_FFFF;
    run_op("R3 xadd16 carry", 1'b0, 2'd1, 4'd3, 64'h1, 64'h0, 3, 1'b0);
    // R3 signed overflow at 32 bits
    mem[4] = 64'h0000_0000_7FFF_FFFF;
    run_op("R3 xadd32 overflow", 1'b0, 2'd2, 4'd4, 64'h1, 64'h0, 1, 1'b0);
    // R4 compare-exchange match at 32 bits
    mem[5] = 64'h9999_9999_CAFE_F00D;
    run_op("R4 cmpxchg32 match", 1'b1, 2'd2, 4'd5, 64'h1111_2222_3333_4444,
           64'h0000_0000_CAFE_F00D, 2, 1'b0);
    chk("R4", "mem after", mem[5], 64'h9999_9999_3333_4444);
    // R5 R12 R11 mismatch at 16 bits, stray start during wait
    mem[6] = 64'h0000_0000_0000_8000;
    run_op("R5 R12 R11 cmpxchg16 miss", 1'b1, 2'd1, 4'd6, 64'h7777,
           64'h0000_0000_0000_0001, 4, 1'b1);
    chk("R5", "mem unchanged", mem[6], 64'h8000);
    // R6 double-width match and mismatch
    mem[7] = 64'h0123_4567_89AB_CDEF;
    run_op("R6 cmpxchg64 match", 1'b1, 2'd3, 4'd7, 64'hFEDC_BA98_7654_3210,
           64'h0123_4567_89AB_CDEF, 1, 1'b0);
    chk("R6", "mem after", mem[7], 64'hFEDC_BA98_7654_3210);
    run_op("R6 cmpxchg64 miss", 1'b1, 2'd3, 4'd7, 64'h0,
           64'hFEDC_BA98_7654_3211, 2, 1'b0);
    // R6 full-width exchange-add
    mem[8] = 64'h8000_0000_0000_0000;
    run_op("R6 xadd64", 1'b0, 2'd3, 4'd8, 64'h8000_0000_0000_0001, 64'h3, 1, 1'b0);
    // R11 stray start during an exchange-add
    mem[9] = 64'h10;
    run_op("R11 xadd8 stray start", 1'b0, 2'd0, 4'd9, 64'h20, 64'h0, 2, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule